// File: doc/BRIEF.md
# General-Purpose I/O Port Controller with Atomic Set and Clear

This block controls one port of general-purpose pins. Software reaches it over a plain 32-bit register bus. The bus has a byte address, a write strobe with write data, and a read strobe with read data. The main register holds four byte lanes:

- the per-pin direction,
- the output level,
- the pad levels seen as reset ended,
- the live, synchronized pad levels.

Two write-only alias registers change output bits without a read-modify-write. Writing a 1 in the output lane of the set alias raises that bit. Writing a 1 in the output lane of the clear alias lowers it. Zeros in either alias leave the output alone.

A fourth register holds the pad configuration: per-pin high drive and per-pin pull-up disable. It accepts only the first write after reset and then stays locked until the next reset. The pads go through a two-flop synchronizer before software or the reset snapshot sees them. Read data is registered, so it appears one clock after the read strobe is sampled.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While rst_n is low at a rising edge, direction, output, read data and pad configuration all become zero. So after reset every pin is an input and pad_oe, pad_out, pad_drv_hi and pad_pu_dis read 0.
- R2: A write to offset 0x0 loads wdata[31:24] into direction, driven on pad_oe (1 = output), and wdata[23:16] into output, driven on pad_out. Both change at the write edge. wdata[15:0] of that write has no effect.
- R3: A read of offset 0x0 returns direction in [31:24], output in [23:16], the reset snapshot in [15:8] and the synchronized pad level in [7:0]. The pad level passes two flops, so a read sampled at the same edge where the pads change still returns the old level.
- R4: A write to offset 0x4 with a 1 in any bit of wdata[23:16] sets the matching output bit. Zeros in that lane leave the bit unchanged.
- R5: A write to offset 0x8 with a 1 in any bit of wdata[23:16] clears the matching output bit. Zeros in that lane leave the bit unchanged.
- R6: Writes to offsets 0x4 and 0x8 ignore wdata[31:24] and wdata[15:0]: direction and the bits not selected stay as they were.
- R7: Bits [15:8] of offset 0x0 hold the synchronized pad level taken at the first rising edge with rst_n high. They keep that value until the next reset, whatever the pads do.
- R8: Offset 0xC holds pad configuration: bits [7:0] drive pad_drv_hi and bits [15:8] drive pad_pu_dis. Only the first write after reset takes effect. Later writes are ignored until reset, and a read of 0xC returns the held value.
- R9: Reads of offsets 0x4 and 0x8 return zero.
- R10: bus_rdata changes only at an edge where bus_rd is sampled high. Otherwise it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 4 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output level |
| pad_drv_hi | output | 8 | Per-pin high-drive select |
| pad_pu_dis | output | 8 | Per-pin pull-up disable |

## Verification
The bench sends set and clear writes that carry ones in their reserved lanes. A design that decoded the whole word would change direction or the wrong output bits.

It reads the pad lane in the same cycle the pads move. A controller without the two-flop delay would return the new level too early. It moves the pads after reset and checks that the snapshot stays put; a snapshot still tracking the pads would fail this.

It writes the configuration register twice and again after a fresh reset. This catches a lock that never engages and a lock that survives reset.

// File: rtl/gpio_port_pkg.sv
// Package: shared constants and register selector for the GPIO port controller.
// Assumes a single port decoded on a 16-byte window of word-aligned registers.
package gpio_port_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 4;
    localparam int LANE_W = 8;

    // Bit positions of the byte lanes inside the data/direction word.
    localparam int LANE_DIR = 24;
    localparam int LANE_OUT = 16;
    localparam int LANE_CAP = 8;
    localparam int LANE_IN  = 0;

    // Register selected by address bits [3:2].
    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_SET  = 2'd1,
        REG_CLR  = 2'd2,
        REG_CFG  = 2'd3
    } gpio_reg_e;
endpackage

// File: rtl/gpio_in_sync.sv
// Module: two-flop pad synchronizer plus a snapshot of the pads at reset release.
// Assumes pads are asynchronous to clk. The synchronizer flops carry no reset,
// so they keep tracking the pads while rst_n is low.
module gpio_in_sync #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] sync_q,
    output logic [NPINS-1:0] cap_q
);
    logic [NPINS-1:0] meta_q;
    logic             cap_done;

    // Two-stage synchronizer for the raw pad levels.
    always_ff @(posedge clk) begin
        meta_q <= pad_in;
        sync_q <= meta_q;
    end

    // Snapshot of the synchronized pads on the first clock after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q    <= '0;
            cap_done <= 1'b0;
        end else if (!cap_done) begin
            cap_q    <= sync_q;
            cap_done <= 1'b1;
        end
    end

    // Once taken, the snapshot never moves until reset.
    assert_capture_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done |=> $stable(cap_q));
endmodule

// File: rtl/gpio_out_regs.sv
// Module: direction and output registers with write-one set and clear aliases.
// Assumes at most one kind of write per cycle from the bus. If several arrive
// together, the full load is applied first, then set, then clear.
module gpio_out_regs #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_we,
    input  logic [NPINS-1:0] dir_wdata,
    input  logic [NPINS-1:0] out_wdata,
    input  logic             set_we,
    input  logic [NPINS-1:0] set_mask,
    input  logic             clr_we,
    input  logic [NPINS-1:0] clr_mask,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] out_q
);
    logic [NPINS-1:0] out_next;

    // Next output value: full load, then set mask, then clear mask.
    always_comb begin
        out_next = out_q;
        if (data_we) out_next = out_wdata;
        if (set_we)  out_next = out_next | set_mask;
        if (clr_we)  out_next = out_next & ~clr_mask;
    end

    // Direction and output state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            out_q <= '0;
        end else begin
            if (data_we) dir_q <= dir_wdata;
            out_q <= out_next;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (dir_q == '0 && out_q == '0));
    assert_data_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        data_we && !set_we && !clr_we |=> (dir_q == $past(dir_wdata) && out_q == $past(out_wdata)));
    assert_set_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_we && !clr_we |=> ((out_q & $past(set_mask)) == $past(set_mask)));
    assert_clear_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((out_q & $past(clr_mask)) == '0));
    assert_alias_keeps_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !data_we |=> $stable(dir_q));
endmodule

// File: rtl/gpio_cfg_lock.sv
// Module: pad configuration register that accepts one write per reset.
// Assumes a write strobe already qualified by the address decode.
module gpio_cfg_lock #(
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_q,
    output logic             locked
);
    // Take the first write, then lock until the next reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            locked <= 1'b0;
        end else if (cfg_we && !locked) begin
            cfg_q  <= cfg_wdata;
            locked <= 1'b1;
        end
    end

    assert_locked_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(locked) |-> $stable(cfg_q));
    assert_first_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && !locked |=> (locked && cfg_q == $past(cfg_wdata)));
endmodule

// File: rtl/gpio_port_ctrl.sv
// Module: top of one GPIO port. Decodes the register bus, assembles the
// read word and drives the pad controls.
// Assumes word-aligned accesses; address bits [1:0] must be zero for a hit.
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_drv_hi,
    output logic [NPINS-1:0]  pad_pu_dis
);
    localparam int CFG_W = 2 * LANE_W;

    gpio_reg_e          reg_sel;
    logic               aligned;
    logic               data_we, set_we, clr_we, cfg_we;
    logic [NPINS-1:0]   sync_q, cap_q, dir_q, out_q;
    logic [CFG_W-1:0]   cfg_q;
    logic               cfg_locked;
    logic [BUS_W-1:0]   data_word;
    logic [BUS_W-1:0]   cfg_word;
    logic [BUS_W-1:0]   rd_next;

    // Address decode into per-register write strobes.
    always_comb begin
        reg_sel = gpio_reg_e'(bus_addr[3:2]);
        aligned = (bus_addr[1:0] == 2'b00);
        data_we = bus_wr && aligned && (reg_sel == REG_DATA);
        set_we  = bus_wr && aligned && (reg_sel == REG_SET);
        clr_we  = bus_wr && aligned && (reg_sel == REG_CLR);
        cfg_we  = bus_wr && aligned && (reg_sel == REG_CFG);
    end

    gpio_in_sync #(.NPINS(NPINS)) u_in_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .sync_q (sync_q),
        .cap_q  (cap_q)
    );

    gpio_out_regs #(.NPINS(NPINS)) u_out_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_we   (data_we),
        .dir_wdata (bus_wdata[LANE_DIR +: NPINS]),
        .out_wdata (bus_wdata[LANE_OUT +: NPINS]),
        .set_we    (set_we),
        .set_mask  (bus_wdata[LANE_OUT +: NPINS]),
        .clr_we    (clr_we),
        .clr_mask  (bus_wdata[LANE_OUT +: NPINS]),
        .dir_q     (dir_q),
        .out_q     (out_q)
    );

    gpio_cfg_lock #(.CFG_W(CFG_W)) u_cfg_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (bus_wdata[CFG_W-1:0]),
        .cfg_q     (cfg_q),
        .locked    (cfg_locked)
    );

    // Assemble the readable words from the lanes.
    always_comb begin
        data_word = '0;
        data_word[LANE_DIR +: NPINS] = dir_q;
        data_word[LANE_OUT +: NPINS] = out_q;
        data_word[LANE_CAP +: NPINS] = cap_q;
        data_word[LANE_IN  +: NPINS] = sync_q;
        cfg_word = '0;
        cfg_word[CFG_W-1:0] = cfg_q;
    end

    // Read multiplexer; the set and clear aliases read as zero.
    always_comb begin
        rd_next = '0;
        if (aligned) begin
            case (reg_sel)
                REG_DATA: rd_next = data_word;
                REG_CFG:  rd_next = cfg_word;
                default:  rd_next = '0;
            endcase
        end
    end

    // Registered read data, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

    // Pad control outputs.
    always_comb begin
        pad_oe     = dir_q;
        pad_out    = out_q;
        pad_drv_hi = cfg_q[NPINS-1:0];
        pad_pu_dis = cfg_q[LANE_W +: NPINS];
    end

    assert_alias_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && aligned && (reg_sel == REG_SET || reg_sel == REG_CLR) |=> (bus_rdata == '0));
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
    assert_cfg_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |=> $stable(pad_drv_hi) && $stable(pad_pu_dis));
endmodule

// File: tb/test_gpio_port_ctrl.sv
`timescale 1ns/1ps
module test_gpio_port_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_oe, pad_out, pad_drv_hi, pad_pu_dis;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    gpio_port_ctrl i_gpio_port_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_drv_hi(pad_drv_hi), .pad_pu_dis(pad_pu_dis)
    );

    // Each entry: {address, write data, expected pad_oe, expected pad_out}.
    localparam logic [51:0] VEC [0:7] = '{
        {4'h0, 32'hF0A5_FFFF, 8'hF0, 8'hA5},   // R2 load, low lanes ignored
        {4'h4, 32'hFF0F_00FF, 8'hF0, 8'hAF},   // R4 set, R6 reserved lanes ignored
        {4'h8, 32'hFF81_FFFF, 8'hF0, 8'h2E},   // R5 clear, R6 reserved lanes ignored
        {4'h4, 32'h0000_0000, 8'hF0, 8'h2E},   // R4 zeros leave output
        {4'h8, 32'h0000_0000, 8'hF0, 8'h2E},   // R5 zeros leave output
        {4'h0, 32'h0F3C_0000, 8'h0F, 8'h3C},   // R2 reload
        {4'h4, 32'h00C3_0000, 8'h0F, 8'hFF},   // R4 set remaining
        {4'h8, 32'h00FF_0000, 8'h0F, 8'h00}    // R5 clear all
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_reset(input logic [7:0] pads);
        @(negedge clk);
        rst_n = 1'b0; pad_in = pads;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [51:0] v;

        do_reset(8'h5A);
        // R1 reset state
        check("R1 pad_oe", {24'h0, pad_oe}, 32'h0);
        check("R1 pad_out", {24'h0, pad_out}, 32'h0);
        check("R1 cfg", {16'h0, pad_pu_dis, pad_drv_hi}, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        bus_read(4'h0, rd);
        check("R3 R7 reset read", rd, 32'h0000_5A5A);

        // R3: pads change in the same cycle as a read; the old level is returned.
        @(negedge clk);
        pad_in = 8'hC3; bus_addr = 4'h0; bus_rd = 1'b1;
        @(posedge clk); #1;
        rd = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        check("R3 sync delay", {24'h0, rd[7:0]}, 32'h5A);
        repeat (3) @(negedge clk);
        bus_read(4'h0, rd);
        check("R3 live input", {24'h0, rd[7:0]}, 32'hC3);
        check("R7 snapshot held", {24'h0, rd[15:8]}, 32'h5A);

        // Vector table: writes, pad outputs and readback of the upper lanes.
        for (int i = 0; i < 8; i++) begin
            v = VEC[i];
            bus_write(v[51:48], v[47:16]);
            check("R2 R4 R5 R6 pad_oe", {24'h0, pad_oe}, {24'h0, v[15:8]});
            check("R2 R4 R5 pad_out", {24'h0, pad_out}, {24'h0, v[7:0]});
            bus_read(4'h0, rd);
            check("R3 readback", {16'h0, rd[31:16]}, {16'h0, v[15:0]});
        end

        // R9 alias reads are zero.
        bus_write(4'h0, 32'hFFFF_0000);
        bus_read(4'h4, rd);
        check("R9 set read", rd, 32'h0);
        bus_read(4'h0, rd);
        check("R3 full word", rd, 32'hFFFF_5AC3);
        bus_read(4'h8, rd);
        check("R9 clear read", rd, 32'h0);

        // R10 read data holds without a read strobe.
        bus_read(4'h0, rd);
        bus_write(4'h8, 32'h00FF_0000);
        repeat (2) @(negedge clk);
        check("R10 hold", bus_rdata, 32'hFFFF_5AC3);

        // R8 write-once configuration.
        bus_write(4'hC, 32'h0000_3355);
        check("R8 first write", {16'h0, pad_pu_dis, pad_drv_hi}, 32'h3355);
        bus_write(4'hC, 32'h0000_FFFF);
        check("R8 second write ignored", {16'h0, pad_pu_dis, pad_drv_hi}, 32'h3355);
        bus_read(4'hC, rd);
        check("R8 readback", rd, 32'h0000_3355);

        // Fresh reset: lock released, new snapshot.
        do_reset(8'h99);
        check("R1 cfg after reset", {16'h0, pad_pu_dis, pad_drv_hi}, 32'h0);
        check("R1 oe after reset", {24'h0, pad_oe}, 32'h0);
        bus_read(4'h0, rd);
        check("R7 new snapshot", rd, 32'h0000_9999);
        bus_write(4'hC, 32'h0000_00AA);
        check("R8 write after reset", {16'h0, pad_pu_dis, pad_drv_hi}, 32'h00AA);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule